// File: doc/BRIEF.md
# Packed Page-Table Entry Writer

This block updates a page table held in a 32-bit word-addressed memory. Each entry is a 27-bit page frame number: the physical address shifted right by 12, for 4 KiB pages. Four consecutive entries are packed bit-contiguously into a 128-bit group of four words. Fields cross word boundaries, so changing only some entries of a group needs a read-modify-write of the whole group. The top bits of the last word carry a group-valid flag.

A command gives a starting entry index, an entry count and a mode. The mode chooses where the frame numbers come from:

- **Span**: a contiguous physical range.
- **List**: a streamed list of page addresses, consumed in entry order.
- **Clear**: unmap the entries.

The block splits the range into an unaligned head, whole aligned groups, and a tail. Whole groups are written straight out. Partial groups are read first, merged and written back. The memory port carries one request at a time.

The controller is a five-state machine:

- **IDLE** accepts a command (IDLE→PLAN, or stays in IDLE for a zero count).
- **PLAN** sizes the next group. It goes PLAN→GATHER, or PLAN→STORE for a zero-filled unmap group.
- **GATHER** collects one frame number per cycle. It goes GATHER→STORE for a whole group, or GATHER→FETCH for a partial one.
- **FETCH** reads four words (FETCH→STORE).
- **STORE** writes four words. It goes STORE→PLAN while entries remain, and STORE→IDLE after the last write is acknowledged.

Top module: `pte_pack_writer`

## Requirements
- R1: Entry lane k (0..3) of a group occupies bits 27k+26..27k of the 128-bit value formed with word 0 least significant. The group of entry index i starts at word address i with its two low bits cleared, and word w of the group is at base+w. Words are always issued in order 0,1,2,3.
- R2: A frame number is bits 38..12 of a physical address. Span mode (cmd_mode=0) gives entry j of the command the address cmd_base + j·0x1000.
- R3: Every word-3 write, other than an all-zero unmap group, has bit 30 set.
- R4: A command starting at lane o with n entries handles min(n, 4−o) entries first when o≠0. It then handles whole groups, then a remainder group. Only partial groups cause reads.
- R5: A partial group reads all four words before writing any of them. Bits outside the targeted fields are preserved, including word-3 bits 31..12 apart from the flag.
- R6: In unmap mode (cmd_mode=2 or 3), entries in a partial group receive the frame number of null_base. A null_base of 0 is accepted and writes zero frames.
- R7: In unmap mode, a whole group is written as four zero words, without reads, only while more than four entries remain. An exact final group of four goes through the partial path, with null frames and the flag set.
- R8: List mode (cmd_mode=1) takes exactly one list entry per table entry, in entry order. list_ready is high only while the block is waiting for a frame.
- R9: cmd_ready is high only when idle. busy rises on the cycle after acceptance and falls after the last write acknowledge.
- R10: A zero-count command is accepted and completes with no memory access; busy never rises.
- R11: mem_req stays high, with stable address, write enable and write data, until mem_ack. Read data is taken on the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_mode | input | 2 | 0 span, 1 list, 2/3 unmap |
| cmd_index | input | IDX_W | First entry index |
| cmd_count | input | CNT_W | Number of entries |
| cmd_base | input | PA_W | Physical start address for span mode |
| null_base | input | PA_W | Physical address of the null page |
| list_valid | input | 1 | List address offered |
| list_ready | output | 1 | List address consumed when high with list_valid |
| list_addr | input | PA_W | Physical address of the next listed page |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | IDX_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request complete; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest case to reach is an unmap whose remainder is an exact aligned group of four. That group must take the read-modify-write path with null frames and the flag set, instead of being zeroed. A twelve-entry unmap starting on a group boundary produces two zeroed groups followed by this case, and a separate four-entry unmap makes it the only group. Memory is pre-filled with a pattern that has non-zero word-3 upper bits, so both the preserved bits and the difference between the zero path and the merge path show up in the table contents and in the read count.

// File: rtl/pte_pack_pkg.sv
package pte_pack_pkg;
    localparam int PFN_W      = 27;
    localparam int PAGE_SHIFT = 12;
    localparam int LANES      = 4;
    localparam int WORD_W     = 32;
    localparam int GROUP_W    = LANES * WORD_W;
    localparam int FLAG_BIT   = 3 * WORD_W + 30;

    typedef enum logic [1:0] {
        MODE_SPAN  = 2'd0,
        MODE_LIST  = 2'd1,
        MODE_CLEAR = 2'd2,
        MODE_WIPE  = 2'd3
    } map_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_GATHER,
        ST_FETCH,
        ST_STORE
    } wr_state_e;
endpackage

// File: rtl/pte_frame_src.sv
module pte_frame_src
    import pte_pack_pkg::*;
(
    input  map_mode_e          mode,
    input  logic [PFN_W-1:0]   span_pfn,
    input  logic [PFN_W-1:0]   list_pfn,
    input  logic [PFN_W-1:0]   null_pfn,
    output logic [PFN_W-1:0]   frame,
    output logic               from_stream
);
    always_comb begin
        from_stream = (mode == MODE_LIST);
        unique case (mode)
            MODE_SPAN: frame = span_pfn;
            MODE_LIST: frame = list_pfn;
            default:   frame = null_pfn;
        endcase
    end
endmodule

// File: rtl/pte_group_merge.sv
module pte_group_merge
    import pte_pack_pkg::*;
(
    input  logic [GROUP_W-1:0]            old_group,
    input  logic [LANES-1:0][PFN_W-1:0]   frames,
    input  logic [LANES-1:0]              lane_sel,
    output logic [GROUP_W-1:0]            new_group
);
    localparam int FIELDS_W = LANES * PFN_W;

    logic [GROUP_W-1:0] merged;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign merged[k*PFN_W +: PFN_W] =
            lane_sel[k] ? frames[k] : old_group[k*PFN_W +: PFN_W];
    end
    assign merged[GROUP_W-1:FIELDS_W] = old_group[GROUP_W-1:FIELDS_W];

    always_comb begin
        new_group           = merged;
        new_group[FLAG_BIT] = 1'b1;
    end
endmodule

// File: rtl/pte_pack_writer.sv
module pte_pack_writer
    import pte_pack_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int CNT_W = 16,
    parameter int PA_W  = 39
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_mode,
    input  logic [IDX_W-1:0] cmd_index,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic [PA_W-1:0]  cmd_base,
    input  logic [PA_W-1:0]  null_base,
    input  logic             list_valid,
    output logic             list_ready,
    input  logic [PA_W-1:0]  list_addr,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata
);
    localparam logic [CNT_W-1:0] FOUR = CNT_W'(LANES);

    wr_state_e                  state_q, state_d;
    map_mode_e                  mode_q;
    logic [IDX_W-1:0]           idx_q;
    logic [CNT_W-1:0]           rem_q;
    logic [PFN_W-1:0]           cursor_q;
    logic [GROUP_W-1:0]         grp_q;
    logic [LANES-1:0][PFN_W-1:0] frames_q;
    logic [LANES-1:0]           sel_q, sel_d;
    logic [2:0]                 take_q, take_d, room, last_w;
    logic [1:0]                 lane_q, last_q, word_q, off;
    logic                       whole_q, whole_d, wipe_q, clearing;
    logic [PFN_W-1:0]           frame;
    logic                       from_stream, step, word_done;
    logic [GROUP_W-1:0]         merged_group, store_group;

    pte_frame_src u_src (
        .mode        (mode_q),
        .span_pfn    (cursor_q),
        .list_pfn    (list_addr[PAGE_SHIFT +: PFN_W]),
        .null_pfn    (null_base[PAGE_SHIFT +: PFN_W]),
        .frame       (frame),
        .from_stream (from_stream)
    );

    pte_group_merge u_merge (
        .old_group (grp_q),
        .frames    (frames_q),
        .lane_sel  (sel_q),
        .new_group (merged_group)
    );

    // Group planning for the entries still to be written
    always_comb begin
        clearing = (mode_q != MODE_SPAN) && (mode_q != MODE_LIST);
        off      = idx_q[1:0];
        room     = 3'd4 - {1'b0, off};
        take_d   = (rem_q < CNT_W'(room)) ? rem_q[2:0] : room;
        last_w   = {1'b0, off} + take_d - 3'd1;
        whole_d  = (off == 2'd0) && (clearing ? (rem_q > FOUR) : (rem_q >= FOUR));
        for (int k = 0; k < LANES; k++) begin
            sel_d[k] = (k >= int'(off)) && (k < int'(off) + int'(take_d));
        end
        step        = !from_stream || list_valid;
        word_done   = mem_ack && (word_q == 2'd3);
        store_group = wipe_q ? '0 : merged_group;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid && cmd_count != '0) state_d = ST_PLAN;
            ST_PLAN:   state_d = (whole_d && clearing) ? ST_STORE : ST_GATHER;
            ST_GATHER: if (step && lane_q == last_q) state_d = whole_q ? ST_STORE : ST_FETCH;
            ST_FETCH:  if (word_done) state_d = ST_STORE;
            ST_STORE:  if (word_done) state_d = (rem_q == CNT_W'(take_q)) ? ST_IDLE : ST_PLAN;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        cmd_ready  = (state_q == ST_IDLE);
        busy       = (state_q != ST_IDLE);
        list_ready = (state_q == ST_GATHER) && from_stream;
        mem_req    = (state_q == ST_FETCH) || (state_q == ST_STORE);
        mem_we     = (state_q == ST_STORE);
        mem_addr   = {idx_q[IDX_W-1:2], word_q};
        mem_wdata  = store_group[{word_q, 5'd0} +: WORD_W];
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_SPAN;
            idx_q    <= '0;
            rem_q    <= '0;
            cursor_q <= '0;
            grp_q    <= '0;
            frames_q <= '0;
            sel_q    <= '0;
            take_q   <= '0;
            lane_q   <= '0;
            last_q   <= '0;
            word_q   <= '0;
            whole_q  <= 1'b0;
            wipe_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (cmd_valid) begin
                    mode_q   <= map_mode_e'(cmd_mode);
                    idx_q    <= cmd_index;
                    rem_q    <= cmd_count;
                    cursor_q <= cmd_base[PAGE_SHIFT +: PFN_W];
                end
                ST_PLAN: begin
                    grp_q   <= '0;
                    sel_q   <= sel_d;
                    take_q  <= take_d;
                    lane_q  <= off;
                    last_q  <= last_w[1:0];
                    whole_q <= whole_d;
                    wipe_q  <= whole_d && clearing;
                    word_q  <= '0;
                end
                ST_GATHER: if (step) begin
                    frames_q[lane_q] <= frame;
                    lane_q           <= lane_q + 2'd1;
                    if (mode_q == MODE_SPAN) cursor_q <= cursor_q + 1'b1;
                end
                ST_FETCH: if (mem_ack) begin
                    grp_q[{word_q, 5'd0} +: WORD_W] <= mem_rdata;
                    word_q <= word_q + 2'd1;
                end
                ST_STORE: if (mem_ack) begin
                    word_q <= word_q + 2'd1;
                    if (word_q == 2'd3) begin
                        idx_q <= idx_q + IDX_W'(take_q);
                        rem_q <= rem_q - CNT_W'(take_q);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pte_pack_writer_chk.sv
module pte_pack_writer_chk #(
    parameter int IDX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_ready,
    input logic             busy,
    input logic             list_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic [IDX_W-1:0] mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_ack
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11

    AST_WORD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_addr[1:0] != 2'd3 |=> mem_req && mem_addr[1:0] == $past(mem_addr[1:0]) + 2'd1); // R1

    AST_GROUP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_addr[1:0] == 2'd3 && mem_wdata != 32'd0 |-> mem_wdata[30]); // R3

    AST_STREAM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        list_ready |-> busy && !mem_req); // R8

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_ready)); // R9

    AST_REQ_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy && !cmd_ready); // R9
endmodule

bind pte_pack_writer pte_pack_writer_chk #(.IDX_W(IDX_W)) chk_i (.*);

// File: tb/pte_pack_writer_tb.sv
module pte_pack_writer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_mode = 2'd0;
    logic [15:0] cmd_index = '0;
    logic [15:0] cmd_count = '0;
    logic [38:0] cmd_base = '0;
    logic [38:0] null_base = '0;
    logic        list_valid, list_ready;
    logic [38:0] list_addr;
    logic        busy, mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    pte_pack_writer dut_i (.*);

    logic [31:0] mem [64];
    logic [31:0] refm [64];
    logic [38:0] lst [16];
    int lst_len = 0;
    int lst_ptr = 0;
    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, acc_cnt = 0, proto_err = 0;
    logic        ack_q = 1'b0;
    logic [31:0] rdata_q = '0;
    logic [15:0] pend_addr = '0;

    assign mem_ack    = ack_q;
    assign mem_rdata  = rdata_q;
    assign list_valid = lst_ptr < lst_len;
    assign list_addr  = lst[lst_ptr[3:0]];

    // Memory model: one-cycle acknowledge, one request at a time
    initial forever begin
        @(posedge clk);
        if (mem_req && !ack_q) begin
            ack_q     <= 1'b1;
            pend_addr <= mem_addr;
            acc_cnt   <= acc_cnt + 1;
            if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
            else begin
                rdata_q <= mem[mem_addr[5:0]];
                rd_cnt  <= rd_cnt + 1;
            end
        end else begin
            if (ack_q && mem_addr != pend_addr) proto_err <= proto_err + 1;
            ack_q <= 1'b0;
        end
    end

    // List stream source
    initial forever begin
        @(posedge clk);
        if (list_valid && list_ready) lst_ptr <= lst_ptr + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected table contents, built from the requirements
    task automatic ref_run(input logic [1:0] md, input int idx, input int cnt,
                           input logic [38:0] base, output int exp_reads);
        int i, r, off, n, lp, gb;
        bit clr, full;
        logic [127:0] g;
        logic [38:0] a;
        logic [26:0] pfn;
        i = idx; r = cnt; a = base; lp = 0; exp_reads = 0;
        clr = (md >= 2'd2);
        while (r > 0) begin
            off  = i % 4;
            n    = (r < 4 - off) ? r : 4 - off;
            full = (off == 0) && (clr ? r > 4 : r >= 4);
            gb   = (i / 4) * 4;
            if (full) g = '0;
            else begin
                g = {refm[gb+3], refm[gb+2], refm[gb+1], refm[gb]};
                exp_reads += 4;
            end
            if (!(full && clr)) begin
                for (int k = off; k < off + n; k++) begin
                    if (md == 2'd0) begin pfn = a[38:12]; a = a + 39'h1000; end
                    else if (md == 2'd1) begin pfn = lst[lp][38:12]; lp++; end
                    else pfn = null_base[38:12];
                    g[27*k +: 27] = pfn;
                end
                g[126] = 1'b1;
            end
            for (int w = 0; w < 4; w++) refm[gb+w] = g[32*w +: 32];
            i += n; r -= n;
        end
    endtask

    task automatic run_cmd(input logic [1:0] md, input int idx, input int cnt,
                           input logic [38:0] base, input string req);
        int exp_reads, bad, first;
        ref_run(md, idx, cnt, base, exp_reads);
        rd_cnt = 0; acc_cnt = 0; lst_ptr = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = md; cmd_index = 16'(idx);
        cmd_count = 16'(cnt); cmd_base = base;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == (cnt != 0), "R9", "busy after accept", 64'(busy), 64'(cnt != 0));
        while (busy) @(negedge clk);
        bad = 0; first = -1;
        for (int w = 0; w < 64; w++)
            if (mem[w] !== refm[w]) begin bad++; if (first < 0) first = w; end
        chk(bad == 0, req, "table contents", first < 0 ? 64'd0 : 64'(mem[first]),
            first < 0 ? 64'd0 : 64'(refm[first]));
        chk(rd_cnt == exp_reads, (md >= 2) ? "R4 R7" : "R4 R5", "read count",
            64'(rd_cnt), 64'(exp_reads));
        if (md == 2'd1) chk(lst_ptr == cnt, "R8", "list entries taken", 64'(lst_ptr), 64'(cnt));
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R9", "reset busy", 64'(busy), 0);
        chk(cmd_ready == 1'b1, "R9", "reset ready", 64'(cmd_ready), 1);
        chk(mem_req == 1'b0, "R11", "reset request", 64'(mem_req), 0);
        chk(list_ready == 1'b0, "R8", "reset list ready", 64'(list_ready), 0);
    endtask

    task automatic t_span_aligned();   // R1 R2 R3
        run_cmd(2'd0, 8, 8, 39'h12_3456_7000, "R1 R2 R3");
        chk(mem[11][30] == 1'b1, "R3", "flag word 11", 64'(mem[11]), 64'(refm[11]));
    endtask

    task automatic t_span_split();     // R4 R5
        run_cmd(2'd0, 5, 9, 39'h40_0000_0000 + 39'h7F_F000, "R4 R5");
    endtask

    task automatic t_list();           // R8
        lst[0] = 39'h11_1111_1000; lst[1] = 39'h7F_FFFF_F000; lst[2] = 39'h00_0000_1000;
        lst[3] = 39'h55_5555_5000; lst[4] = 39'h2A_AAAA_A000; lst[5] = 39'h3C_3C3C_3000;
        lst_len = 6;
        run_cmd(2'd1, 17, 6, '0, "R8 R2");
        lst_len = 0;
    endtask

    task automatic t_clear_run();      // R6 R7
        null_base = 39'h00_00AB_C000;
        run_cmd(2'd2, 32, 12, '0, "R6 R7");
        chk(mem[35] == 32'd0, "R7", "zeroed group word 3", 64'(mem[35]), 0);
        chk(mem[43][30] == 1'b1, "R7", "final four flag", 64'(mem[43]), 64'(refm[43]));
    endtask

    task automatic t_clear_exact_four(); // R7
        run_cmd(2'd3, 0, 4, '0, "R7");
    endtask

    task automatic t_clear_null_zero(); // R6
        null_base = '0;
        run_cmd(2'd2, 50, 2, '0, "R6");
    endtask

    task automatic t_zero_count();     // R10
        bit seen_busy;
        seen_busy = 1'b0;
        acc_cnt = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = 2'd0; cmd_index = 16'd20; cmd_count = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int c = 0; c < 6; c++) begin
            if (busy) seen_busy = 1'b1;
            @(negedge clk);
        end
        chk(!seen_busy, "R10", "busy on zero count", 64'(seen_busy), 0);
        chk(acc_cnt == 0, "R10", "accesses on zero count", 64'(acc_cnt), 0);
        chk(cmd_ready == 1'b1, "R10", "ready after zero count", 64'(cmd_ready), 1);
    endtask

    task automatic t_mid_lanes();      // R5
        run_cmd(2'd0, 61, 2, 39'h01_0000_3000, "R5 R1");
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int w = 0; w < 64; w++) begin
            mem[w]  = 32'hA5C3_0000 ^ (32'(w) * 32'h0101_0F07);
            refm[w] = mem[w];
        end
        for (int k = 0; k < 16; k++) lst[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_span_aligned();
        t_span_split();
        t_list();
        t_clear_run();
        t_clear_exact_four();
        t_clear_null_zero();
        t_zero_count();
        t_mid_lanes();
        chk(proto_err == 0, "R11", "request changed before ack", 64'(proto_err), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule